// File: doc/BRIEF.md
# Partitioned LRU Way Replacement Unit

This block keeps recency order for every set of a four-way set-associative cache placed in front of slow flash. On each miss it chooses the victim way. The choice is true least-recently-used order, but it only looks at a subset of ways. That subset depends on whether the access is an instruction fetch or a data read, and on a two-bit partition setting. The same setting lets the ways be shared by both access types, split two and two, or split three and one.

The cache controller drives the set index together with a hit report or an allocate request. In the same cycle it reads back the victim way. Recency for each set lives in flops as four 2-bit ages, where age 0 is the most recent way. The ages change on the clock edge that ends a hit or an enabled allocate. The partition setting is taken into the block only during cycles with no request.

Top module: `part_lru_repl`

## Requirements
- R1: After reset every set holds ages 3, 2, 1, 0 for ways 0 to 3. A cold set therefore offers the lowest-numbered way its access type may use.
- R2: With partition code 0, instruction and data misses both choose the oldest of all four ways.
- R3: With partition code 1, an instruction miss (acc_is_data = 0) chooses the older of ways 0 and 1. A data miss (acc_is_data = 1) chooses the older of ways 2 and 3.
- R4: With partition code 2, an instruction miss chooses the oldest of ways 0, 1 and 2. A data miss always chooses way 3.
- R5: victim_vld is high only when alloc_req is high and caching is enabled for the current type (icache_en for instructions, dcache_en for data). victim_way is the combinational choice from the current ages in that same cycle.
- R6: An allocate for a type whose cache enable is low leaves recency unchanged and keeps victim_vld low.
- R7: On an enabled allocate, the victim becomes age 0. On a hit, the way given by hit_way (binary 0 to 3) becomes age 0. In both cases every way that was younger than the touched way ages by one, and the change takes effect at the next clock edge.
- R8: A hit on a way outside the accessing type's partition still updates that way's recency.
- R9: The partition setting is captured only at a clock edge that ends a cycle in which hit_vld and alloc_req are both low. Changes made during busy cycles have no effect until then. The reset setting is code 0.
- R10: Partition code 3 behaves exactly like code 0.
- R11: Recency updates touch only the set given by set_idx. Other sets are unaffected.
- R12: When an enabled allocate and a hit occur in the same cycle, only the allocate updates recency. A hit that comes with a disabled allocate does update recency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_idx | input | SET_W | Set addressed this cycle |
| hit_vld | input | 1 | A lookup hit this cycle |
| hit_way | input | 2 | Way that hit |
| alloc_req | input | 1 | Miss requesting a victim |
| acc_is_data | input | 1 | 1 = data read, 0 = instruction fetch |
| part_mode | input | 2 | Partition code, 0 to 3 |
| icache_en | input | 1 | Caching enabled for instruction fetches |
| dcache_en | input | 1 | Caching enabled for data reads |
| victim_vld | output | 1 | victim_way is a usable allocation |
| victim_way | output | 2 | Chosen victim way |

## Verification
The hardest case to reach from the ports is recency state that is not visible at all: disabled-type allocates and hits outside the partition. The only way to see their effect is through victim choices made later. The bench therefore uses an allocate with caching disabled as a read of the set's oldest allowed way that changes nothing. It mixes these reads with long pseudo-random runs of hits, allocates, combined hit-and-allocate cycles and partition-code changes during busy cycles. A per-set age model in the bench predicts every victim.

// File: rtl/part_lru_repl_pkg.sv
package part_lru_repl_pkg;

    localparam int NUM_WAYS = 4;
    localparam int WAY_W    = $clog2(NUM_WAYS);

    typedef logic [WAY_W-1:0] way_t;
    typedef logic [WAY_W-1:0] age_t;
    typedef age_t [NUM_WAYS-1:0] age_vec_t;
    typedef logic [NUM_WAYS-1:0] way_mask_t;

    typedef enum logic [1:0] {
        PM_SHARED    = 2'd0,
        PM_HALVES    = 2'd1,
        PM_THREE_ONE = 2'd2,
        PM_SPARE     = 2'd3
    } part_mode_e;

    // Ways a given access type may evict under a partition code.
    function automatic way_mask_t allowed_ways(part_mode_e mode, logic is_data);
        way_mask_t m;
        case (mode)
            PM_HALVES:    m = is_data ? 4'b1100 : 4'b0011;
            PM_THREE_ONE: m = is_data ? 4'b1000 : 4'b0111;
            default:      m = 4'b1111;
        endcase
        return m;
    endfunction

    // Make way w the most recent; ways younger than it grow one step older.
    function automatic age_vec_t touch_ages(age_vec_t a, way_t w);
        age_vec_t r;
        r = a;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (a[i] < a[w]) begin
                r[i] = a[i] + age_t'(1);
            end
        end
        r[w] = '0;
        return r;
    endfunction

    // Cold ordering: way 0 oldest, highest way youngest.
    function automatic age_vec_t cold_ages();
        age_vec_t r;
        for (int i = 0; i < NUM_WAYS; i++) begin
            r[i] = age_t'(NUM_WAYS - 1 - i);
        end
        return r;
    endfunction

endpackage

// File: rtl/part_lru_repl_mode_latch.sv
module part_lru_repl_mode_latch
    import part_lru_repl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       busy,
    input  logic [1:0] mode_in,
    output part_mode_e mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_SHARED;
        end else if (!busy) begin
            mode_q <= part_mode_e'(mode_in);
        end
    end
endmodule

// File: rtl/part_lru_repl_age_bank.sv
module part_lru_repl_age_bank
    import part_lru_repl_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] idx,
    input  logic             upd_en,
    input  way_t             upd_way,
    output age_vec_t         ages
);
    age_vec_t set_ages [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                set_ages[s] <= cold_ages();
            end else if (upd_en && (idx == SET_W'(s))) begin
                set_ages[s] <= touch_ages(set_ages[s], upd_way);
            end
        end
    end

    assign ages = set_ages[idx];
endmodule

// File: rtl/part_lru_repl_victim_pick.sv
module part_lru_repl_victim_pick
    import part_lru_repl_pkg::*;
(
    input  age_vec_t  ages,
    input  way_mask_t mask,
    output way_t      victim
);
    always_comb begin
        age_t best_age;
        logic found;
        victim   = '0;
        best_age = '0;
        found    = 1'b0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (mask[i] && (!found || ages[i] > best_age)) begin
                victim   = way_t'(i);
                best_age = ages[i];
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/part_lru_repl.sv
module part_lru_repl
    import part_lru_repl_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  logic             hit_vld,
    input  logic [1:0]       hit_way,
    input  logic             alloc_req,
    input  logic             acc_is_data,
    input  logic [1:0]       part_mode,
    input  logic             icache_en,
    input  logic             dcache_en,
    output logic             victim_vld,
    output logic [1:0]       victim_way
);
    part_mode_e mode_q;
    age_vec_t   cur_ages;
    way_mask_t  mask;
    way_t       pick;
    logic       type_en;
    logic       do_alloc;
    logic       upd_en;
    way_t       upd_way;

    part_lru_repl_mode_latch u_mode (
        .clk     (clk),
        .rst     (rst),
        .busy    (hit_vld | alloc_req),
        .mode_in (part_mode),
        .mode_q  (mode_q)
    );

    assign mask = allowed_ways(mode_q, acc_is_data);

    part_lru_repl_victim_pick u_pick (
        .ages   (cur_ages),
        .mask   (mask),
        .victim (pick)
    );

    assign type_en  = acc_is_data ? dcache_en : icache_en;
    assign do_alloc = alloc_req & type_en;
    assign upd_en   = do_alloc | hit_vld;
    assign upd_way  = do_alloc ? pick : way_t'(hit_way);

    part_lru_repl_age_bank #(.NUM_SETS(NUM_SETS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .idx     (set_idx),
        .upd_en  (upd_en),
        .upd_way (upd_way),
        .ages    (cur_ages)
    );

    assign victim_vld = do_alloc;
    assign victim_way = pick;
endmodule

// File: rtl/part_lru_repl_chk.sv
module part_lru_repl_chk
    import part_lru_repl_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       hit_vld,
    input logic       alloc_req,
    input logic       acc_is_data,
    input logic       icache_en,
    input logic       dcache_en,
    input logic       victim_vld,
    input logic [1:0] victim_way,
    input logic [1:0] mode_q,
    input logic [7:0] cur_ages
);
    logic [3:0] ages_seen;
    always_comb begin
        ages_seen = '0;
        for (int i = 0; i < 4; i++) begin
            ages_seen[cur_ages[2*i +: 2]] = 1'b1;
        end
    end

    AST_VLD_ONLY_ON_ALLOC: assert property (@(posedge clk) disable iff (rst)
        victim_vld |-> alloc_req); // R5

    AST_DISABLED_NO_VLD: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && (acc_is_data ? !dcache_en : !icache_en)) |-> !victim_vld); // R6

    AST_DATA_WAY3_MODE2: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && acc_is_data && mode_q == 2'd2) |-> victim_way == 2'd3); // R4

    AST_HALVES_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && mode_q == 2'd1) |-> victim_way[1] == acc_is_data); // R3

    AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (hit_vld || alloc_req) |=> mode_q == $past(mode_q)); // R9

    AST_AGES_PERMUTATION: assert property (@(posedge clk) disable iff (rst)
        ages_seen == 4'hF); // R7
endmodule

bind part_lru_repl part_lru_repl_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .hit_vld     (hit_vld),
    .alloc_req   (alloc_req),
    .acc_is_data (acc_is_data),
    .icache_en   (icache_en),
    .dcache_en   (dcache_en),
    .victim_vld  (victim_vld),
    .victim_way  (victim_way),
    .mode_q      (mode_q),
    .cur_ages    (cur_ages)
);

// File: tb/part_lru_repl_tb_top.sv
`timescale 1ns/1ps
module part_lru_repl_tb_top;
    localparam int NUM_SETS = 16;
    localparam int SET_W    = $clog2(NUM_SETS);

    logic             clk = 1'b0;
    logic             rst;
    logic [SET_W-1:0] set_idx;
    logic             hit_vld;
    logic [1:0]       hit_way;
    logic             alloc_req;
    logic             acc_is_data;
    logic [1:0]       part_mode;
    logic             icache_en;
    logic             dcache_en;
    logic             victim_vld;
    logic [1:0]       victim_way;

    int checks = 0;
    int errors = 0;

    int m_age [NUM_SETS][4];
    int m_mode;

    always #2.5 clk = ~clk;

    part_lru_repl #(.NUM_SETS(NUM_SETS)) dut_i (
        .clk(clk), .rst(rst), .set_idx(set_idx), .hit_vld(hit_vld),
        .hit_way(hit_way), .alloc_req(alloc_req), .acc_is_data(acc_is_data),
        .part_mode(part_mode), .icache_en(icache_en), .dcache_en(dcache_en),
        .victim_vld(victim_vld), .victim_way(victim_way)
    );

    function automatic int mask_of(int mode, bit isd);
        if (mode == 1) return isd ? 12 : 3;
        if (mode == 2) return isd ? 8 : 7;
        return 15;
    endfunction

    function automatic int model_victim(int s, int mode, bit isd);
        int best = -1;
        int best_age = -1;
        int mk = mask_of(mode, isd);
        for (int w = 0; w < 4; w++) begin
            if (mk[w] && m_age[s][w] > best_age) begin
                best = w;
                best_age = m_age[s][w];
            end
        end
        return best;
    endfunction

    task automatic model_touch(int s, int w);
        int t = m_age[s][w];
        for (int i = 0; i < 4; i++) if (m_age[s][i] < t) m_age[s][i]++;
        m_age[s][w] = 0;
    endtask

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(int s, bit hv, int hw, bit al, bit isd, int pm,
                        bit ien, bit den, string tag);
        bit en;
        int ev;
        @(negedge clk);
        set_idx = SET_W'(s); hit_vld = hv; hit_way = 2'(hw); alloc_req = al;
        acc_is_data = isd; part_mode = 2'(pm); icache_en = ien; dcache_en = den;
        #1;
        en = isd ? den : ien;
        ev = model_victim(s, m_mode, isd);
        check(tag, "victim_vld", int'(victim_vld), int'(al && en));
        check(tag, "victim_way", int'(victim_way), ev);
        @(posedge clk);
        if (al && en) model_touch(s, ev);
        else if (hv) model_touch(s, hw);
        if (!hv && !al) m_mode = pm;
    endtask

    // Allocate with caching disabled: reveals the victim without changing state.
    task automatic peek(int s, bit isd, string tag);
        step(s, 0, 0, 1, isd, m_mode, isd, !isd, tag);
    endtask

    task automatic set_mode(int pm);
        step(0, 0, 0, 0, 0, pm, 1, 1, "R9");
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; set_idx = '0; hit_vld = 0; hit_way = '0; alloc_req = 0;
        acc_is_data = 0; part_mode = '0; icache_en = 1; dcache_en = 1;
        for (int s = 0; s < NUM_SETS; s++)
            for (int w = 0; w < 4; w++) m_age[s][w] = 3 - w;
        m_mode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        check("R5", "victim_vld after reset", int'(victim_vld), 0);

        // R1: cold sets offer the lowest allowed way, per type and mode
        for (int s = 0; s < NUM_SETS; s++) begin
            peek(s, 0, "R1");
            peek(s, 1, "R1");
        end
        set_mode(1);
        peek(3, 0, "R1"); peek(3, 1, "R1");
        set_mode(2);
        peek(3, 0, "R1"); peek(3, 1, "R1");
        set_mode(0);

        // R11: allocate in set 4 leaves set 5 cold
        step(4, 0, 0, 1, 0, 0, 1, 1, "R11");
        peek(5, 0, "R11");
        peek(4, 0, "R7");

        // R7: hits on set 7 in order 2,0,3,1 leave way 2 oldest
        step(7, 1, 2, 0, 0, 0, 1, 1, "R7");
        step(7, 1, 0, 0, 0, 0, 1, 1, "R7");
        step(7, 1, 3, 0, 0, 0, 1, 1, "R7");
        step(7, 1, 1, 0, 0, 0, 1, 1, "R7");
        peek(7, 0, "R7");

        // R6: disabled allocates in a row change nothing
        step(8, 0, 0, 1, 1, 0, 1, 0, "R6");
        step(8, 0, 0, 1, 1, 0, 1, 0, "R6");
        peek(8, 1, "R6");

        // R12: allocate wins over a simultaneous hit; disabled allocate lets hit through
        step(9, 1, 3, 1, 0, 0, 1, 1, "R12");
        peek(9, 0, "R12");
        step(9, 1, 1, 1, 0, 0, 0, 1, "R12");
        peek(9, 0, "R12");

        // R9: mode changes during busy cycles are held off
        step(10, 1, 0, 0, 1, 1, 1, 1, "R9");
        step(10, 0, 0, 1, 1, 2, 1, 1, "R9");
        peek(11, 1, "R9");
        set_mode(2);
        peek(11, 1, "R9");
        set_mode(0);

        // R8: in mode 1 an instruction hit on way 3 updates recency
        set_mode(1);
        step(12, 1, 3, 0, 0, 1, 1, 1, "R8");
        step(12, 1, 2, 0, 0, 1, 1, 1, "R8");
        peek(12, 1, "R8");

        // Randomised sweep across every partition code
        for (int md = 0; md < 4; md++) begin
            set_mode(md);
            for (int n = 0; n < 500; n++) begin
                int  s   = $urandom % NUM_SETS;
                int  op  = $urandom % 8;
                int  hw  = $urandom % 4;
                bit  isd = 1'($urandom % 2);
                bit  ien = ($urandom % 5) != 0;
                bit  den = ($urandom % 5) != 0;
                bit  hv  = (op >= 3 && op <= 6);
                bit  al  = (op <= 2 || op == 6);
                int  pm  = (hv || al) ? int'($urandom % 4) : md;
                bit  en  = isd ? den : ien;
                string tag;
                if (md == 0) tag = "R2";
                else if (md == 1) tag = "R3";
                else if (md == 2) tag = "R4";
                else tag = "R10";
                if (!al) tag = "R5";
                else if (!en) tag = "R6";
                if (hv && al) tag = "R12";
                else if (hv && !mask_of(md, isd)[hw]) tag = "R8";
                step(s, hv, hw, al, isd, pm, ien, den, tag);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule